// File: doc/BRIEF.md
# Four-Slot Forwarding Register File

This block holds the architectural integer registers for a core that issues four instructions per clock. Each instruction slot has its own single-cycle ALU outside the block, and every slot retires in the same cycle it issues. Each slot presents two source register numbers and gets their operand values back combinationally. In the same cycle it presents an optional destination number together with the result from its ALU.

The slots are ordered. A slot sees the results of every lower-numbered slot in the same cycle, as if the four instructions ran one after another. When more than one lower slot writes the source register, the value comes from the closest one. At the clock edge every enabled result is written into the array, so up to four registers change per cycle. When several slots target one register, the highest-numbered slot's value is the one that stays. There is no pipeline, so a committed value is read on the next cycle with no added delay.

Register 0 is hardwired to zero. Each slot has a write enable and a cancel input. The issue logic uses the cancel input to drop the slots that follow a blocking instruction. A slot that is disabled or cancelled has no effect on any operand and leaves the array unchanged.

Top module: `quad_fwd_regfile`

## Requirements
- R1: While reset is low, every register is cleared. After reset, any register that has not been written since reads as zero.
- R2: A source operand whose register is not written by any lower-numbered active slot in the cycle returns the value held in the array.
- R3: A source operand whose register is written by one or more lower-numbered active slots returns the result of the highest-numbered of those slots, in the same cycle.
- R4: A slot never sees its own result or the result of a higher-numbered slot in the same cycle.
- R5: When several active slots write the same register in one cycle, the array keeps the value from the highest-numbered of them.
- R6: Source register number 0 always returns zero. A result aimed at register 0 is neither forwarded nor stored.
- R7: A slot whose write enable is low forwards nothing and stores nothing.
- R8: A slot whose cancel input is high forwards nothing and stores nothing, whatever its write enable.
- R9: Four active slots with distinct destinations all store their results at one clock edge, and the new values are readable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are stored on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset that clears the array |
| rs1_idx | input | NS*IW | First source register number per slot; slot k uses bits [k*IW +: IW] |
| rs2_idx | input | NS*IW | Second source register number per slot, same layout |
| rd_idx | input | NS*IW | Destination register number per slot, same layout |
| wr_en | input | NS | Per-slot result valid; bit k belongs to slot k |
| kill | input | NS | Per-slot cancel; bit k belongs to slot k |
| rd_data | input | NS*XLEN | Per-slot result value; slot k uses bits [k*XLEN +: XLEN] |
| rs1_val | output | NS*XLEN | First operand value per slot, same layout as rd_data |
| rs2_val | output | NS*XLEN | Second operand value per slot, same layout as rd_data |

## Verification
The assertions assume that each slot's result and destination are stable and settled before the clock edge. They also assume the external ALUs form no combinational loop: a slot's result may depend only on its own operands, which come from lower slots. The bench acts as the ALUs and drives results straight from its own stimulus, so that assumption holds by construction. All inputs change away from the clock edge. The random phase limits register numbers to a small range that includes zero, so collisions between slots, writes aimed at register 0, and cancelled or disabled writers occur often.

// File: rtl/quad_fwd_regfile.sv
module quad_fwd_regfile #(
  parameter int NS       = 4,
  parameter int NUM_REGS = 32,
  parameter int XLEN     = 32,
  parameter int IW       = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NS*IW-1:0]     rs1_idx,
  input  logic [NS*IW-1:0]     rs2_idx,
  input  logic [NS*IW-1:0]     rd_idx,
  input  logic [NS-1:0]        wr_en,
  input  logic [NS-1:0]        kill,
  input  logic [NS*XLEN-1:0]   rd_data,
  output logic [NS*XLEN-1:0]   rs1_val,
  output logic [NS*XLEN-1:0]   rs2_val
);

  logic [XLEN-1:0] regs [NUM_REGS];
  logic [NS-1:0]   live;

  for (genvar j = 0; j < NS; j++) begin : g_live
    assign live[j] = wr_en[j] & ~kill[j] & (rd_idx[j*IW +: IW] != '0);
  end

  for (genvar k = 0; k < NS; k++) begin : g_slot
    logic [IW-1:0]   a1, a2;
    logic [XLEN-1:0] v1, v2;

    assign a1 = rs1_idx[k*IW +: IW];
    assign a2 = rs2_idx[k*IW +: IW];

    always_comb begin
      v1 = (a1 == '0) ? '0 : regs[a1];
      v2 = (a2 == '0) ? '0 : regs[a2];
      for (int j = 0; j < k; j++) begin
        if (live[j] && rd_idx[j*IW +: IW] == a1) v1 = rd_data[j*XLEN +: XLEN];
        if (live[j] && rd_idx[j*IW +: IW] == a2) v2 = rd_data[j*XLEN +: XLEN];
      end
    end

    assign rs1_val[k*XLEN +: XLEN] = v1;
    assign rs2_val[k*XLEN +: XLEN] = v2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      for (int j = 0; j < NS; j++)
        if (live[j]) regs[rd_idx[j*IW +: IW]] <= rd_data[j*XLEN +: XLEN];
    end
  end

endmodule

// File: rtl/quad_fwd_regfile_chk.sv
module quad_fwd_regfile_chk #(
  parameter int NS   = 4,
  parameter int XLEN = 32,
  parameter int IW   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NS*IW-1:0]   rs1_idx,
  input logic [NS*IW-1:0]   rs2_idx,
  input logic [NS*IW-1:0]   rd_idx,
  input logic [NS-1:0]      wr_en,
  input logic [NS-1:0]      kill,
  input logic [NS*XLEN-1:0] rd_data,
  input logic [NS*XLEN-1:0] rs1_val,
  input logic [NS*XLEN-1:0] rs2_val
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rs1_val[XLEN-1:0] == '0 && rs2_val[XLEN-1:0] == '0));

  for (genvar k = 0; k < NS; k++) begin : g_zero
    a_r6_zero_src1: assert property (@(posedge clk) disable iff (!rst_n)
      (rs1_idx[k*IW +: IW] == '0) |-> (rs1_val[k*XLEN +: XLEN] == '0));
    a_r6_zero_src2: assert property (@(posedge clk) disable iff (!rst_n)
      (rs2_idx[k*IW +: IW] == '0) |-> (rs2_val[k*XLEN +: XLEN] == '0));
  end

  for (genvar k = 1; k < NS; k++) begin : g_fwd
    a_r3_fwd_nearest: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[k-1] && !kill[k-1] && rd_idx[(k-1)*IW +: IW] != '0
       && rd_idx[(k-1)*IW +: IW] == rs1_idx[k*IW +: IW])
      |-> (rs1_val[k*XLEN +: XLEN] == rd_data[(k-1)*XLEN +: XLEN]));
  end

  a_r5_last_slot_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[NS-1] && !kill[NS-1] && rd_idx[(NS-1)*IW +: IW] != '0)
    |=> (rs1_idx[IW-1:0] != $past(rd_idx[(NS-1)*IW +: IW])
         || rs1_val[XLEN-1:0] == $past(rd_data[(NS-1)*XLEN +: XLEN])));

endmodule

bind quad_fwd_regfile quad_fwd_regfile_chk #(.NS(NS), .XLEN(XLEN), .IW(IW)) u_chk (.*);

// File: tb/quad_fwd_regfile_tb.sv
module quad_fwd_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NR = 32;
  localparam int XL = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS*IW-1:0] rs1_idx, rs2_idx, rd_idx;
  logic [NS-1:0] wr_en, kill;
  logic [NS*XL-1:0] rd_data, rs1_val, rs2_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_fwd_regfile u_dut (.*);

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [XL-1:0] model [NR];
  int s_rs1[NS], s_rs2[NS], s_rd[NS];
  bit s_we[NS], s_kill[NS];
  logic [XL-1:0] s_dat[NS];

  task automatic clear_slots();
    for (int k = 0; k < NS; k++) begin
      s_rs1[k] = 0; s_rs2[k] = 0; s_rd[k] = 0;
      s_we[k] = 0; s_kill[k] = 0; s_dat[k] = '0;
    end
  endtask

  task automatic check(string tag, logic [XL-1:0] act, logic [XL-1:0] exp, int k, int src);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s slot %0d src%0d: actual %h expected %h", tag, k, src, act, exp);
    end
  endtask

  // Drives one bundle, compares operands with sequential-execution model, commits at edge.
  task automatic step(string tag);
    logic [XL-1:0] shadow [NR];
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      rs1_idx[k*IW +: IW] = IW'(s_rs1[k]);
      rs2_idx[k*IW +: IW] = IW'(s_rs2[k]);
      rd_idx[k*IW +: IW]  = IW'(s_rd[k]);
      wr_en[k] = s_we[k];
      kill[k]  = s_kill[k];
      rd_data[k*XL +: XL] = s_dat[k];
    end
    #1;
    shadow = model;
    for (int k = 0; k < NS; k++) begin
      check(tag, rs1_val[k*XL +: XL], shadow[s_rs1[k]], k, 1);
      check(tag, rs2_val[k*XL +: XL], shadow[s_rs2[k]], k, 2);
      if (s_we[k] && !s_kill[k] && s_rd[k] != 0) shadow[s_rd[k]] = s_dat[k];
    end
    if (rst_n) model = shadow;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    clear_slots();
    rs1_idx = '0; rs2_idx = '0; rd_idx = '0; wr_en = '0; kill = '0; rd_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 0; i < NR; i += 8) begin
      clear_slots();
      for (int k = 0; k < NS; k++) begin s_rs1[k] = i + 2*k; s_rs2[k] = i + 2*k + 1; end
      step("R1");
    end

    // R9: four distinct writes in one edge, then read them all
    clear_slots();
    for (int k = 0; k < NS; k++) begin
      s_rd[k] = k + 1; s_we[k] = 1; s_dat[k] = 32'hA000_0000 + k; s_rs1[k] = 20; s_rs2[k] = 21;
    end
    step("R9");
    clear_slots();
    for (int k = 0; k < NS; k++) begin s_rs1[k] = k + 1; s_rs2[k] = 4 - k; end
    step("R9");

    // R3: nearest earlier writer forwards
    clear_slots();
    s_rd[0] = 5; s_we[0] = 1; s_dat[0] = 32'h1111_1111;
    s_rd[2] = 5; s_we[2] = 1; s_dat[2] = 32'h2222_2222;
    s_rs1[1] = 5; s_rs1[2] = 5; s_rs1[3] = 5; s_rs2[3] = 5;
    step("R3");

    // R4: own and later results not visible
    clear_slots();
    s_rd[2] = 7; s_we[2] = 1; s_dat[2] = 32'hBEEF_0007;
    s_rs1[1] = 7; s_rs1[2] = 7; s_rs2[2] = 7; s_rs1[0] = 7;
    step("R4");

    // R5: two writers to one register, highest slot stays
    clear_slots();
    s_rd[1] = 8; s_we[1] = 1; s_dat[1] = 32'h0000_0801;
    s_rd[3] = 8; s_we[3] = 1; s_dat[3] = 32'h0000_0803;
    step("R5");
    clear_slots(); s_rs1[0] = 8; s_rs2[2] = 8; step("R5");

    // R6: register 0 ignores writes and never forwards
    clear_slots();
    s_rd[0] = 0; s_we[0] = 1; s_dat[0] = 32'hFFFF_FFFF;
    s_rs1[1] = 0; s_rs2[3] = 0;
    step("R6");
    clear_slots(); step("R6");

    // R7: disabled write has no effect
    clear_slots();
    s_rd[0] = 9; s_we[0] = 0; s_dat[0] = 32'hDEAD_0009; s_rs1[1] = 9;
    step("R7");
    clear_slots(); s_rs1[0] = 9; step("R7");

    // R8: cancelled write has no effect
    clear_slots();
    s_rd[1] = 2; s_we[1] = 1; s_kill[1] = 1; s_dat[1] = 32'hDEAD_0002;
    s_rs1[2] = 2; s_rs2[3] = 2;
    step("R8");
    clear_slots(); s_rs1[0] = 2; s_rs2[1] = 2; step("R8");

    // R2/R3: random bundles over a narrow register range
    for (int n = 0; n < 2000; n++) begin
      for (int k = 0; k < NS; k++) begin
        s_rs1[k] = $urandom_range(0, 5); s_rs2[k] = $urandom_range(0, 5);
        s_rd[k] = $urandom_range(0, 5);
        s_we[k] = ($urandom_range(0, 3) != 0); s_kill[k] = ($urandom_range(0, 5) == 0);
        s_dat[k] = $urandom;
      end
      step("R2");
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule